// File: doc/BRIEF.md
# Node-local address translator

This block takes a system physical address and works out whether the node's memory controller owns it. If it does, the block converts it to an offset inside the node's DRAM, and then to a compacted address that a chip-select decoder can use. The DRAM offset comes from one of two rules. The first is a relocation window: a range of DRAM that was hoisted above the 4 GiB line to make room for a memory-mapped I/O gap. Addresses inside that window have a hole offset taken off. Every other address has the node's base taken off its low 40 bits. The compacted address then drops the node-interleave select bits, which sit just above the 4 KiB page offset, and keeps the page offset as it is.

A request is a one-cycle pulse on `reqValid`. The address and every configuration field are captured on that edge. The results appear one clock later, together with a one-cycle `rspValid` pulse. They are held until the next request. There is no back-pressure, and requests may arrive on consecutive cycles.

Top module: `node_addr_xlate`

## Requirements
- R1: `rspValid` is high for exactly one cycle, in the cycle after each cycle in which `reqValid` is high, and is low otherwise. A synchronous active-high `rst` clears `rspValid`, `nodeHit`, `dramAddr`, `inputAddr` and `badCode` to zero.
- R2: `nodeHit` is 1 exactly when `dramBase <= sysAddr[39:0] <= dramLimit`. This is an unsigned, inclusive, 40-bit comparison. When `nodeHit` is 0, the other data outputs carry no meaning.
- R3: When `holeValid` is 1 and 0x1_0000_0000 <= `sysAddr` < 0x1_0000_0000 + `holeSize`, `dramAddr` is the low 40 bits of `sysAddr - holeOffset`.
- R4: The relocation window excludes its upper bound and everything below 0x1_0000_0000. With `holeValid` = 0 no address is relocated.
- R5: Outside the relocation window, `dramAddr` is `sysAddr[39:0] - dramBase`, modulo 2^40. Bits 63 to 40 of `sysAddr` have no effect on it.
- R6: The 3-bit `intlvCode` selects an interleave shift: 0 gives 0, 1 gives 1, 3 gives 2, 7 gives 3, and every other code gives 0.
- R7: `inputAddr[11:0]` equals `dramAddr[11:0]`. `inputAddr[35:12]` equals bits 35 to 12 of `dramAddr` shifted right by the interleave shift.
- R8: `badCode` is 1 for `intlvCode` values 2, 4, 5 and 6, and 0 for 0, 1, 3 and 7.
- R9: Between requests the outputs hold their last values. Changes to the address or configuration inputs while `reqValid` is low have no effect on them.
- R10: Each request uses the address and configuration present in its own `reqValid` cycle, including requests on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request pulse; inputs are captured on this edge |
| sysAddr | input | 64 | System physical address |
| dramBase | input | 40 | Lowest system address owned by the node |
| dramLimit | input | 40 | Highest system address owned by the node |
| holeValid | input | 1 | Enables the relocation window |
| holeOffset | input | 40 | Amount taken off relocated addresses |
| holeSize | input | 40 | Length of the relocation window above 4 GiB |
| intlvCode | input | 3 | Node-interleave enable code |
| rspValid | output | 1 | Result pulse, one cycle after the request |
| nodeHit | output | 1 | Address lies within base..limit |
| dramAddr | output | 40 | Node-local DRAM address |
| inputAddr | output | 36 | DRAM address with the interleave bits removed |
| badCode | output | 1 | Interleave code is not one of 0, 1, 3, 7 |

## Verification
A vector table drives each of the four legal interleave codes, and one illegal code, over a single address. This separates the shift amounts and shows the page offset surviving the shift. Further vectors sit on the base and limit bounds, just outside them, and at the edges of the relocation window with the window enabled and disabled. Because the base-subtract and hole-subtract results differ for the same address, a wrong path choice shows up in `dramAddr`. Directed sequences then check the reset values, the holding of outputs while the inputs wander, and back-to-back requests with different codes.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic capture;  // load the registers with this cycle's result
    logic clear;    // return the registers to zero
  } xlateStrobes_t;

  // Interleave code to shift count; an unlisted code gives 0.
  function automatic logic [1:0] intlvShift(input logic [2:0] code);
    case (code)
      3'd1:    return 2'd1;
      3'd3:    return 2'd2;
      3'd7:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic intlvLegal(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd3) || (code == 3'd7);
  endfunction

endpackage

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          reqValid,
  output xlateStrobes_t strobes,
  output logic          rspValid
);

  always_comb begin
    strobes.clear   = rst;
    strobes.capture = reqValid && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) rspValid <= 1'b0;
    else     rspValid <= reqValid;
  end

endmodule

// File: rtl/xlate_dp.sv
module xlate_dp
  import xlate_pkg::*;
#(
  parameter int SYS_W    = 64,
  parameter int PHYS_W   = 40,
  parameter int IN_W     = 36,
  parameter int PAGE_W   = 12,
  parameter int HOLE_BIT = 32
) (
  input  logic              clk,
  input  xlateStrobes_t     strobes,
  input  logic [SYS_W-1:0]  sysAddr,
  input  logic [PHYS_W-1:0] dramBase,
  input  logic [PHYS_W-1:0] dramLimit,
  input  logic              holeValid,
  input  logic [PHYS_W-1:0] holeOffset,
  input  logic [PHYS_W-1:0] holeSize,
  input  logic [2:0]        intlvCode,
  output logic              nodeHit,
  output logic [PHYS_W-1:0] dramAddr,
  output logic [IN_W-1:0]   inputAddr,
  output logic              badCode
);

  localparam int MAX_SHIFT = 3;
  localparam int EXT_W     = SYS_W - PHYS_W;
  localparam logic [SYS_W-1:0] HOLE_START = {{(SYS_W-1){1'b0}}, 1'b1} << HOLE_BIT;

  logic [PHYS_W-1:0] sysLow;
  logic [SYS_W-1:0]  holeEnd;
  logic [SYS_W-1:0]  holeDiff;
  logic [PHYS_W-1:0] baseDiff;
  logic              inHole;
  logic              hitNext;
  logic [PHYS_W-1:0] dramNext;
  logic [IN_W-1:0]   inputNext;
  logic [1:0]        shiftSel;
  logic [IN_W-1:0]   candidate [MAX_SHIFT+1];

  always_comb begin
    sysLow   = sysAddr[PHYS_W-1:0];
    hitNext  = (sysLow >= dramBase) && (sysLow <= dramLimit);
    holeEnd  = HOLE_START + {{EXT_W{1'b0}}, holeSize};
    inHole   = holeValid && (sysAddr >= HOLE_START) && (sysAddr < holeEnd);
    holeDiff = sysAddr - {{EXT_W{1'b0}}, holeOffset};
    baseDiff = sysLow - dramBase;
    dramNext = inHole ? holeDiff[PHYS_W-1:0] : baseDiff;
    shiftSel = intlvShift(intlvCode);
  end

  // One compacted candidate per possible shift count.
  for (genvar g = 0; g <= MAX_SHIFT; g++) begin : g_shift
    logic [PHYS_W-1:0] shifted;
    assign shifted      = dramNext >> g;
    assign candidate[g] = {shifted[IN_W-1:PAGE_W], dramNext[PAGE_W-1:0]};
  end

  assign inputNext = candidate[shiftSel];

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      nodeHit   <= 1'b0;
      dramAddr  <= '0;
      inputAddr <= '0;
      badCode   <= 1'b0;
    end else if (strobes.capture) begin
      nodeHit   <= hitNext;
      dramAddr  <= dramNext;
      inputAddr <= inputNext;
      badCode   <= !intlvLegal(intlvCode);
    end
  end

endmodule

// File: rtl/node_addr_xlate.sv
module node_addr_xlate
  import xlate_pkg::*;
#(
  parameter int SYS_W    = 64,
  parameter int PHYS_W   = 40,
  parameter int IN_W     = 36,
  parameter int PAGE_W   = 12,
  parameter int HOLE_BIT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [SYS_W-1:0]  sysAddr,
  input  logic [PHYS_W-1:0] dramBase,
  input  logic [PHYS_W-1:0] dramLimit,
  input  logic              holeValid,
  input  logic [PHYS_W-1:0] holeOffset,
  input  logic [PHYS_W-1:0] holeSize,
  input  logic [2:0]        intlvCode,
  output logic              rspValid,
  output logic              nodeHit,
  output logic [PHYS_W-1:0] dramAddr,
  output logic [IN_W-1:0]   inputAddr,
  output logic              badCode
);

  xlateStrobes_t strobes;

  xlate_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  xlate_dp #(
    .SYS_W    (SYS_W),
    .PHYS_W   (PHYS_W),
    .IN_W     (IN_W),
    .PAGE_W   (PAGE_W),
    .HOLE_BIT (HOLE_BIT)
  ) i_dp (
    .clk        (clk),
    .strobes    (strobes),
    .sysAddr    (sysAddr),
    .dramBase   (dramBase),
    .dramLimit  (dramLimit),
    .holeValid  (holeValid),
    .holeOffset (holeOffset),
    .holeSize   (holeSize),
    .intlvCode  (intlvCode),
    .nodeHit    (nodeHit),
    .dramAddr   (dramAddr),
    .inputAddr  (inputAddr),
    .badCode    (badCode)
  );

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
  parameter int SYS_W  = 64,
  parameter int PHYS_W = 40,
  parameter int IN_W   = 36,
  parameter int PAGE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic [SYS_W-1:0]  sysAddr,
  input logic [PHYS_W-1:0] dramBase,
  input logic [PHYS_W-1:0] dramLimit,
  input logic [2:0]        intlvCode,
  input logic              rspValid,
  input logic              nodeHit,
  input logic [PHYS_W-1:0] dramAddr,
  input logic [IN_W-1:0]   inputAddr,
  input logic              badCode
);

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

  p_hit_range_r2: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> nodeHit == (($past(sysAddr[PHYS_W-1:0]) >= $past(dramBase)) &&
                             ($past(sysAddr[PHYS_W-1:0]) <= $past(dramLimit))));

  p_page_kept_r7: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> inputAddr[PAGE_W-1:0] == dramAddr[PAGE_W-1:0]);

  p_no_shift_r6: assert property (@(posedge clk) disable iff (rst)
    (reqValid && intlvCode == 3'd0) |=> inputAddr == dramAddr[IN_W-1:0]);

  p_bad_code_r8: assert property (@(posedge clk) disable iff (rst)
    (reqValid && (intlvCode == 3'd2 || intlvCode == 3'd4 ||
                  intlvCode == 3'd5 || intlvCode == 3'd6)) |=> badCode);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> $stable(dramAddr) && $stable(inputAddr) &&
                  $stable(nodeHit) && $stable(badCode));

endmodule

bind node_addr_xlate xlate_chk #(
  .SYS_W  (SYS_W),
  .PHYS_W (PHYS_W),
  .IN_W   (IN_W),
  .PAGE_W (PAGE_W)
) i_chk (
  .clk       (clk),
  .rst       (rst),
  .reqValid  (reqValid),
  .sysAddr   (sysAddr),
  .dramBase  (dramBase),
  .dramLimit (dramLimit),
  .intlvCode (intlvCode),
  .rspValid  (rspValid),
  .nodeHit   (nodeHit),
  .dramAddr  (dramAddr),
  .inputAddr (inputAddr),
  .badCode   (badCode)
);

// File: tb/test_node_addr_xlate.sv
module test_node_addr_xlate;

  logic        clk = 1'b0;
  logic        rst;
  logic        reqValid;
  logic [63:0] sysAddr;
  logic [39:0] dramBase;
  logic [39:0] dramLimit;
  logic        holeValid;
  logic [39:0] holeOffset;
  logic [39:0] holeSize;
  logic [2:0]  intlvCode;
  logic        rspValid;
  logic        nodeHit;
  logic [39:0] dramAddr;
  logic [35:0] inputAddr;
  logic        badCode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  node_addr_xlate i_node_addr_xlate (
    .clk(clk), .rst(rst), .reqValid(reqValid), .sysAddr(sysAddr),
    .dramBase(dramBase), .dramLimit(dramLimit), .holeValid(holeValid),
    .holeOffset(holeOffset), .holeSize(holeSize), .intlvCode(intlvCode),
    .rspValid(rspValid), .nodeHit(nodeHit), .dramAddr(dramAddr),
    .inputAddr(inputAddr), .badCode(badCode)
  );

  typedef struct packed {
    logic [63:0] sys;
    logic [39:0] base;
    logic [39:0] limit;
    logic        hv;
    logic [39:0] hoff;
    logic [39:0] hsize;
    logic [2:0]  code;
    logic        eHit;
    logic [39:0] eDram;
    logic [35:0] eInp;
    logic        eBad;
  } vec_t;

  localparam logic [39:0] ALL = 40'hFF_FFFF_FFFF;
  localparam logic [39:0] G1  = 40'h00_4000_0000;

  localparam vec_t VECS [0:16] = '{
    // R6 R7: one address under each legal code, then an illegal one (R8)
    '{64'h1234_5678, 40'h0, ALL, 1'b0, 40'h0, 40'h0, 3'd0, 1'b1, 40'h1234_5678, 36'h0_1234_5678, 1'b0},
    '{64'h1234_5678, 40'h0, ALL, 1'b0, 40'h0, 40'h0, 3'd1, 1'b1, 40'h1234_5678, 36'h0_091A_2678, 1'b0},
    '{64'h1234_5678, 40'h0, ALL, 1'b0, 40'h0, 40'h0, 3'd3, 1'b1, 40'h1234_5678, 36'h0_048D_1678, 1'b0},
    '{64'h1234_5678, 40'h0, ALL, 1'b0, 40'h0, 40'h0, 3'd7, 1'b1, 40'h1234_5678, 36'h0_0246_8678, 1'b0},
    '{64'h1234_5678, 40'h0, ALL, 1'b0, 40'h0, 40'h0, 3'd5, 1'b1, 40'h1234_5678, 36'h0_1234_5678, 1'b1},
    // R5: base subtraction, then upper bits ignored
    '{64'h20_0000_1ABC, 40'h20_0000_0000, 40'h3F_FFFF_FFFF, 1'b0, 40'h0, 40'h0, 3'd0, 1'b1, 40'h1ABC, 36'h1ABC, 1'b0},
    '{64'hFFFF_FF80_0000_5000, 40'h80_0000_0000, ALL, 1'b0, 40'h0, 40'h0, 3'd0, 1'b1, 40'h5000, 36'h5000, 1'b0},
    // R2: just below the base, just above the limit, on the limit, on the base
    '{64'h1F_FFFF_FFFF, 40'h20_0000_0000, 40'h3F_FFFF_FFFF, 1'b0, 40'h0, 40'h0, 3'd0, 1'b0, 40'h0, 36'h0, 1'b0},
    '{64'h40_0000_0000, 40'h20_0000_0000, 40'h3F_FFFF_FFFF, 1'b0, 40'h0, 40'h0, 3'd0, 1'b0, 40'h0, 36'h0, 1'b0},
    '{64'h3F_FFFF_FFFF, 40'h20_0000_0000, 40'h3F_FFFF_FFFF, 1'b0, 40'h0, 40'h0, 3'd0, 1'b1, 40'h1F_FFFF_FFFF, 36'hF_FFFF_FFFF, 1'b0},
    '{64'h20_0000_0000, 40'h20_0000_0000, 40'h3F_FFFF_FFFF, 1'b0, 40'h0, 40'h0, 3'd0, 1'b1, 40'h0, 36'h0, 1'b0},
    // R3: window start, last window byte; R4: window end, below 4 GiB, disabled
    '{64'h1_0000_0000, 40'h0, ALL, 1'b1, G1, G1, 3'd0, 1'b1, 40'h00_C000_0000, 36'h0_C000_0000, 1'b0},
    '{64'h1_3FFF_FFFF, 40'h0, ALL, 1'b1, G1, G1, 3'd0, 1'b1, 40'h00_FFFF_FFFF, 36'h0_FFFF_FFFF, 1'b0},
    '{64'h1_4000_0000, 40'h0, ALL, 1'b1, G1, G1, 3'd0, 1'b1, 40'h01_4000_0000, 36'h1_4000_0000, 1'b0},
    '{64'h0_FFFF_FFFF, 40'h0, ALL, 1'b1, G1, G1, 3'd0, 1'b1, 40'h00_FFFF_FFFF, 36'h0_FFFF_FFFF, 1'b0},
    '{64'h1_0000_0000, 40'h0, ALL, 1'b0, G1, G1, 3'd0, 1'b1, 40'h01_0000_0000, 36'h1_0000_0000, 1'b0},
    // R3 R7: relocated address with shift 2
    '{64'h1_0000_2345, 40'h0, ALL, 1'b1, G1, G1, 3'd3, 1'b1, 40'h00_C000_2345, 36'h0_3000_0345, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic applyVec(input vec_t v);
    sysAddr = v.sys; dramBase = v.base; dramLimit = v.limit;
    holeValid = v.hv; holeOffset = v.hoff; holeSize = v.hsize; intlvCode = v.code;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      finishRun();
    end
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0;
    applyVec(VECS[0]);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rspValid == 1'b0, "R1 reset rspValid", 64'(rspValid), 0);
    chk(dramAddr == '0 && inputAddr == '0 && !nodeHit && !badCode, "R1 reset outputs",
        {nodeHit, badCode, dramAddr}, 0);
    rst = 1'b0;
    @(negedge clk);

    // Table walk
    for (int i = 0; i <= 16; i++) begin
      applyVec(VECS[i]);
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      chk(rspValid == 1'b1, "R1 rspValid pulse", 64'(rspValid), 1);
      chk(nodeHit == VECS[i].eHit, "R2 nodeHit", 64'(nodeHit), 64'(VECS[i].eHit));
      if (VECS[i].eHit) begin
        chk(dramAddr == VECS[i].eDram, "R3/R4/R5 dramAddr", 64'(dramAddr), 64'(VECS[i].eDram));
        chk(inputAddr == VECS[i].eInp, "R6/R7 inputAddr", 64'(inputAddr), 64'(VECS[i].eInp));
      end
      chk(badCode == VECS[i].eBad, "R8 badCode", 64'(badCode), 64'(VECS[i].eBad));
      @(negedge clk);
      chk(rspValid == 1'b0, "R1 single pulse", 64'(rspValid), 0);
    end

    // R8: the other illegal codes
    for (int c = 2; c <= 6; c += 2) begin
      applyVec(VECS[0]);
      intlvCode = 3'(c);
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      chk(badCode == 1'b1, "R8 illegal code flag", 64'(badCode), 1);
      chk(inputAddr == 36'h0_1234_5678, "R6 illegal code zero shift", 64'(inputAddr), 64'h1234_5678);
    end

    // R10: back-to-back requests with different codes
    applyVec(VECS[0]);
    reqValid = 1'b1;
    @(negedge clk);
    intlvCode = 3'd7;
    chk(inputAddr == 36'h0_1234_5678, "R10 first of pair", 64'(inputAddr), 64'h1234_5678);
    @(negedge clk);
    reqValid = 1'b0;
    chk(rspValid == 1'b1, "R1 second pulse", 64'(rspValid), 1);
    chk(inputAddr == 36'h0_0246_8678, "R10 second of pair", 64'(inputAddr), 64'h0246_8678);

    // R9: inputs wander with no request; outputs stay put
    sysAddr = 64'h1_0000_0000; holeValid = 1'b1; holeOffset = G1; holeSize = G1;
    intlvCode = 3'd2; dramBase = 40'h10;
    repeat (3) @(negedge clk);
    chk(rspValid == 1'b0, "R9 no response without request", 64'(rspValid), 0);
    chk(inputAddr == 36'h0_0246_8678, "R9 inputAddr held", 64'(inputAddr), 64'h0246_8678);
    chk(dramAddr == 40'h1234_5678, "R9 dramAddr held", 64'(dramAddr), 64'h1234_5678);
    chk(badCode == 1'b0, "R9 badCode held", 64'(badCode), 0);

    // R1: reset mid-run clears outputs
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(dramAddr == '0 && inputAddr == '0 && !rspValid, "R1 reset clears",
        64'(dramAddr), 0);

    finishRun();
  end

endmodule